// File: doc/BRIEF.md
# Maintenance Window Address Translator

This block turns processor accesses to a 4 MB address window into configuration-space maintenance requests for a serial interconnect. Software first loads a translation register. It holds the target device ID, the number of switch hops to reach that device, and the word-aligned upper part of the configuration offset. Software then sets the enable bit in a separate window attribute register. After that, each load or store that lands in the window produces one request record. The record carries the target ID, the hop count, the full configuration offset, the access size, a big-endian byte-lane mask and the write data placed onto those lanes.

Only one request is outstanding at a time. While a request waits for its response, `bus_ready` is low and the host bus is stalled. When the response arrives, the block completes the access with an acknowledge or an error pulse. Read data is pulled from the big-endian lanes and returned right-justified. An access outside the window, or any access while the window is disabled, is never forwarded and is answered with an error pulse in the next cycle.

Top module: `maint_win_xlate`

## Requirements
- R1: After reset, `bus_ready` is 1, `mreq_valid`, `bus_ack` and `bus_err` are 0, and both configuration registers read as zero.
- R2: With `cfg_sel`=0 the translation register is written and read back as all 32 bits. With `cfg_sel`=1 only bit 31 (window enable) is stored, and bits 30..0 read as zero.
- R3: An access is accepted when `bus_req` and `bus_ready` are both 1 on a clock edge. If the enable is set and address bits 31..22 equal those of the window base, `mreq_valid` is 1 for exactly the one cycle that follows the acceptance.
- R4: An access with a different address bits 31..22, or any access while the enable is clear, issues no request. It gives a one-cycle `bus_err` in the cycle after acceptance, and `bus_ready` stays 1.
- R5: The request fields are built from the translation register and the access address. Target ID = translation bits 31..22. Hop count = translation bits 19..12. Offset = ({translation bits 11..0, nine zero bits} + address bits 21..0), modulo 2^24.
- R6: `bus_size` gives a byte count: 1 gives `mreq_size`=00, 2 gives 01, and any other value gives 10 (four bytes).
- R7: Lanes are big-endian. Lane mask bit 3 covers data bits 31..24, and byte address k (address bits 1..0) sits in bits 31-8k..24-8k. The masks are: a 1-byte access uses mask bit 3-k; a 2-byte access uses 1100 when address bit 1 is 0 and 0011 when it is 1 (address bit 0 ignored); a 4-byte access uses 1111. Right-justified write data is shifted onto those lanes, and the other lanes are zero.
- R8: On read completion, the response bytes on the access's lanes are returned right-justified in `bus_rdata`, with the upper bits zero.
- R9: From acceptance until completion `bus_ready` is 0. A `bus_req` in that time is ignored: it raises no request and no error.
- R10: A `rsp_valid` while waiting completes the access in the next cycle. The completion is `bus_ack` when `rsp_err` is 0 and `bus_err` when it is 1, and `bus_ready` then returns to 1. A write acknowledge carries `bus_rdata`=0.
- R11: A translation register write in the same cycle as an acceptance takes effect only for later accesses; the accepted request uses the previous value.
- R12: The request fields hold their values while the request is outstanding, even if the translation register is rewritten meanwhile.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 1 | Register select: 0 translation, 1 window attribute |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Read-back of the selected register |
| bus_req | input | 1 | Host access request strobe |
| bus_we | input | 1 | Host access is a write |
| bus_addr | input | 32 | Host byte address |
| bus_size | input | 3 | Host access byte count |
| bus_wdata | input | 32 | Right-justified host write data |
| bus_ready | output | 1 | Block can accept an access |
| bus_ack | output | 1 | Access completed successfully |
| bus_err | output | 1 | Access refused or failed |
| bus_rdata | output | 32 | Right-justified read data, valid with `bus_ack` |
| mreq_valid | output | 1 | Request record issued this cycle |
| mreq_we | output | 1 | Request is a write |
| mreq_dest | output | 10 | Target device ID |
| mreq_hop | output | 8 | Hop count |
| mreq_offset | output | 24 | Configuration byte offset |
| mreq_size | output | 2 | Size code: 00 one, 01 two, 10 four bytes |
| mreq_lanes | output | 4 | Big-endian byte-lane mask |
| mreq_wdata | output | 32 | Write data on its lanes |
| rsp_valid | input | 1 | Response for the outstanding request |
| rsp_err | input | 1 | Response reports failure |
| rsp_rdata | input | 32 | Response data, big-endian lanes |

## Verification
A register write and the acceptance of a window access can land on the same clock edge. The bench drives `cfg_wr` with a new translation value in the same cycle as `bus_req`. The scoreboard expects the issued request to carry the old target ID and offset, and the next access to carry the new ones. The same kind of overlap is also provoked by rewriting the translation register while a request is outstanding. The bench then samples the request ports before the response and requires them to be unchanged. In a third overlap, a second `bus_req` is driven while the block is stalled. It must raise neither a request nor an error.

// File: rtl/mwt_pkg.sv
package mwt_pkg;

    localparam int DATA_W     = 32;
    localparam int ADDR_W     = 32;
    localparam int DEST_W     = 10;
    localparam int HOP_W      = 8;
    localparam int OFF_W      = 24;
    localparam int XOFF_W     = 12;
    localparam int XOFF_SHIFT = 9;
    localparam int WIN_BITS   = 22;
    localparam int LANES      = DATA_W / 8;
    localparam int DEST_LSB   = DATA_W - DEST_W;
    localparam int HOP_LSB    = 12;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10
    } acc_size_e;

    typedef struct packed {
        logic [DEST_W-1:0] dest;
        logic [HOP_W-1:0]  hop;
        logic [OFF_W-1:0]  offset;
        logic              we;
        acc_size_e         size;
        logic [LANES-1:0]  lanes;
        logic [DATA_W-1:0] wdata;
    } maint_req_t;

    function automatic acc_size_e decode_size(input logic [2:0] nbytes);
        case (nbytes)
            3'd1:    return SZ_BYTE;
            3'd2:    return SZ_HALF;
            default: return SZ_WORD;
        endcase
    endfunction

    function automatic logic [LANES-1:0] lane_mask(input acc_size_e sz, input logic [1:0] a);
        case (sz)
            SZ_BYTE: return 4'b1000 >> a;
            SZ_HALF: return a[1] ? 4'b0011 : 4'b1100;
            default: return 4'b1111;
        endcase
    endfunction

    function automatic logic [4:0] lane_shift(input acc_size_e sz, input logic [1:0] a);
        case (sz)
            SZ_BYTE: begin
                case (a)
                    2'd0:    return 5'd24;
                    2'd1:    return 5'd16;
                    2'd2:    return 5'd8;
                    default: return 5'd0;
                endcase
            end
            SZ_HALF: return a[1] ? 5'd0 : 5'd16;
            default: return 5'd0;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] size_bits(input acc_size_e sz);
        case (sz)
            SZ_BYTE: return 32'h0000_00FF;
            SZ_HALF: return 32'h0000_FFFF;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] place_write(input logic [DATA_W-1:0] d,
                                                      input acc_size_e sz, input logic [1:0] a);
        return (d & size_bits(sz)) << lane_shift(sz, a);
    endfunction

    function automatic logic [DATA_W-1:0] extract_read(input logic [DATA_W-1:0] d,
                                                       input acc_size_e sz, input logic [1:0] a);
        return (d >> lane_shift(sz, a)) & size_bits(sz);
    endfunction

endpackage

// File: rtl/mwt_cfg.sv
module mwt_cfg
    import mwt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr,
    input  logic              cfg_sel,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] cfg_rdata,
    output logic [DATA_W-1:0] xlat,
    output logic              win_en
);

    always_ff @(posedge clk) begin
        if (rst) begin
            xlat   <= '0;
            win_en <= 1'b0;
        end else if (cfg_wr) begin
            if (cfg_sel) win_en <= cfg_wdata[DATA_W-1];
            else         xlat   <= cfg_wdata;
        end
    end

    always_comb begin
        if (cfg_sel) cfg_rdata = {win_en, {(DATA_W-1){1'b0}}};
        else         cfg_rdata = xlat;
    end

endmodule

// File: rtl/mwt_decode.sv
module mwt_decode
    import mwt_pkg::*;
#(
    parameter logic [ADDR_W-1:0] WIN_BASE = 32'hF000_0000
)(
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [2:0]        bus_size,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] xlat,
    input  logic              win_en,
    output logic              hit,
    output maint_req_t        rec
);

    localparam int TAG_W = ADDR_W - WIN_BITS;

    logic [TAG_W-1:0] addr_tag;
    logic             unused_xlat_bits;
    acc_size_e        sz;

    assign addr_tag         = bus_addr[ADDR_W-1:WIN_BITS];
    assign hit              = win_en && (addr_tag == WIN_BASE[ADDR_W-1:WIN_BITS]);
    assign unused_xlat_bits = ^xlat[DEST_LSB-1:HOP_LSB+HOP_W];
    assign sz               = decode_size(bus_size);

    always_comb begin
        rec.dest   = xlat[DATA_W-1:DEST_LSB];
        rec.hop    = xlat[HOP_LSB+HOP_W-1:HOP_LSB];
        rec.offset = OFF_W'({xlat[XOFF_W-1:0], {XOFF_SHIFT{1'b0}}})
                   + OFF_W'(bus_addr[WIN_BITS-1:0]);
        rec.we     = bus_we;
        rec.size   = sz;
        rec.lanes  = lane_mask(sz, bus_addr[1:0]);
        rec.wdata  = place_write(bus_wdata, sz, bus_addr[1:0]);
    end

endmodule

// File: rtl/mwt_ctrl.sv
module mwt_ctrl
    import mwt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_req,
    input  logic              hit,
    input  maint_req_t        rec_in,
    input  logic              rsp_valid,
    input  logic              rsp_err,
    input  logic [DATA_W-1:0] rsp_rdata,
    output logic              bus_ready,
    output logic              bus_ack,
    output logic              bus_err,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              mreq_valid,
    output maint_req_t        rec_q
);

    typedef enum logic {ST_IDLE, ST_WAIT} st_e;

    st_e  state;
    logic accept;

    assign bus_ready = (state == ST_IDLE);
    assign accept    = bus_req && bus_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            mreq_valid <= 1'b0;
            bus_ack    <= 1'b0;
            bus_err    <= 1'b0;
            bus_rdata  <= '0;
            rec_q      <= '0;
        end else begin
            mreq_valid <= 1'b0;
            bus_ack    <= 1'b0;
            bus_err    <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        if (hit) begin
                            rec_q      <= rec_in;
                            mreq_valid <= 1'b1;
                            state      <= ST_WAIT;
                        end else begin
                            bus_err   <= 1'b1;
                            bus_rdata <= '0;
                        end
                    end
                end
                default: begin
                    if (rsp_valid) begin
                        state <= ST_IDLE;
                        if (rsp_err) begin
                            bus_err   <= 1'b1;
                            bus_rdata <= '0;
                        end else begin
                            bus_ack   <= 1'b1;
                            bus_rdata <= rec_q.we ? '0
                                       : extract_read(rsp_rdata, rec_q.size, rec_q.offset[1:0]);
                        end
                    end
                end
            endcase
        end
    end

    assert_ready_low_R9: assert property (@(posedge clk) disable iff (rst)
        mreq_valid |-> !bus_ready);

    assert_no_back_to_back_R9: assert property (@(posedge clk) disable iff (rst)
        mreq_valid |=> !mreq_valid);

    assert_ack_needs_rsp_R10: assert property (@(posedge clk) disable iff (rst)
        bus_ack |-> $past(rsp_valid && !rsp_err));

    assert_done_exclusive_R10: assert property (@(posedge clk) disable iff (rst)
        $onehot0({bus_ack, bus_err}));

    assert_lane_count_R7: assert property (@(posedge clk) disable iff (rst)
        mreq_valid |-> ($countones(rec_q.lanes) ==
                        ((rec_q.size == SZ_BYTE) ? 1 : (rec_q.size == SZ_HALF) ? 2 : 4)));

    assert_record_held_R12: assert property (@(posedge clk) disable iff (rst)
        (!bus_ready && !mreq_valid) |-> $stable(rec_q));

endmodule

// File: rtl/maint_win_xlate.sv
module maint_win_xlate
    import mwt_pkg::*;
#(
    parameter logic [31:0] WIN_BASE = 32'hF000_0000
)(
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_wr,
    input  logic        cfg_sel,
    input  logic [31:0] cfg_wdata,
    output logic [31:0] cfg_rdata,
    input  logic        bus_req,
    input  logic        bus_we,
    input  logic [31:0] bus_addr,
    input  logic [2:0]  bus_size,
    input  logic [31:0] bus_wdata,
    output logic        bus_ready,
    output logic        bus_ack,
    output logic        bus_err,
    output logic [31:0] bus_rdata,
    output logic        mreq_valid,
    output logic        mreq_we,
    output logic [9:0]  mreq_dest,
    output logic [7:0]  mreq_hop,
    output logic [23:0] mreq_offset,
    output logic [1:0]  mreq_size,
    output logic [3:0]  mreq_lanes,
    output logic [31:0] mreq_wdata,
    input  logic        rsp_valid,
    input  logic        rsp_err,
    input  logic [31:0] rsp_rdata
);

    logic [DATA_W-1:0] xlat;
    logic              win_en;
    logic              hit;
    maint_req_t        rec_d;
    maint_req_t        rec_q;

    mwt_cfg u_cfg (
        .clk       (clk),
        .rst       (rst),
        .cfg_wr    (cfg_wr),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .xlat      (xlat),
        .win_en    (win_en)
    );

    mwt_decode #(.WIN_BASE(WIN_BASE)) u_dec (
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_size  (bus_size),
        .bus_wdata (bus_wdata),
        .xlat      (xlat),
        .win_en    (win_en),
        .hit       (hit),
        .rec       (rec_d)
    );

    mwt_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .bus_req    (bus_req),
        .hit        (hit),
        .rec_in     (rec_d),
        .rsp_valid  (rsp_valid),
        .rsp_err    (rsp_err),
        .rsp_rdata  (rsp_rdata),
        .bus_ready  (bus_ready),
        .bus_ack    (bus_ack),
        .bus_err    (bus_err),
        .bus_rdata  (bus_rdata),
        .mreq_valid (mreq_valid),
        .rec_q      (rec_q)
    );

    assign mreq_we     = rec_q.we;
    assign mreq_dest   = rec_q.dest;
    assign mreq_hop    = rec_q.hop;
    assign mreq_offset = rec_q.offset;
    assign mreq_size   = rec_q.size;
    assign mreq_lanes  = rec_q.lanes;
    assign mreq_wdata  = rec_q.wdata;

    assert_enable_gate_R4: assert property (@(posedge clk) disable iff (rst)
        mreq_valid |-> $past(win_en));

    assert_window_hit_R3: assert property (@(posedge clk) disable iff (rst)
        mreq_valid |-> ($past(bus_addr[31:WIN_BITS]) == WIN_BASE[31:WIN_BITS]));

endmodule

// File: tb/tb_maint_win_xlate.sv
module tb_maint_win_xlate;

    localparam logic [31:0] BASE = 32'hF000_0000;

    typedef logic [31:0] tag_t;
    typedef struct packed {
        logic [9:0]  dest;
        logic [7:0]  hop;
        logic [23:0] off;
        logic        we;
        logic [1:0]  size;
        logic [3:0]  lanes;
        logic [31:0] wdata;
        tag_t        tag;
    } exp_req_t;
    typedef struct packed {
        logic        err;
        logic [31:0] rdata;
        tag_t        tag;
    } exp_done_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr = 1'b0, cfg_sel = 1'b0;
    logic [31:0] cfg_wdata = '0, cfg_rdata;
    logic        bus_req = 1'b0, bus_we = 1'b0;
    logic [31:0] bus_addr = '0, bus_wdata = '0, bus_rdata;
    logic [2:0]  bus_size = 3'd4;
    logic        bus_ready, bus_ack, bus_err;
    logic        mreq_valid, mreq_we;
    logic [9:0]  mreq_dest;
    logic [7:0]  mreq_hop;
    logic [23:0] mreq_offset;
    logic [1:0]  mreq_size;
    logic [3:0]  mreq_lanes;
    logic [31:0] mreq_wdata;
    logic        rsp_valid = 1'b0, rsp_err = 1'b0;
    logic [31:0] rsp_rdata = '0;

    always #4 clk = ~clk;

    maint_win_xlate #(.WIN_BASE(BASE)) dut (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_ready(bus_ready), .bus_ack(bus_ack),
        .bus_err(bus_err), .bus_rdata(bus_rdata), .mreq_valid(mreq_valid), .mreq_we(mreq_we),
        .mreq_dest(mreq_dest), .mreq_hop(mreq_hop), .mreq_offset(mreq_offset),
        .mreq_size(mreq_size), .mreq_lanes(mreq_lanes), .mreq_wdata(mreq_wdata),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata)
    );

    exp_req_t  rq[$];
    exp_done_t dq[$];
    exp_req_t  er;
    exp_done_t ed;
    int n_chk  = 0;
    int n_fail = 0;
    logic [31:0] sh_xlat = '0;
    logic        sh_en   = 1'b0;

    task automatic chk(input bit ok, input tag_t tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    function automatic logic [1:0] sz_code(input int n);
        if (n == 1) return 2'b00;
        if (n == 2) return 2'b01;
        return 2'b10;
    endfunction

    function automatic logic [31:0] exp_read(input logic [31:0] d, input int n, input logic [1:0] a);
        if (n == 1) return {24'h0, d[31-8*a -: 8]};
        if (n == 2) return a[1] ? {16'h0, d[15:0]} : {16'h0, d[31:16]};
        return d;
    endfunction

    function automatic exp_req_t mk(input logic we, input logic [31:0] a, input int n,
                                    input logic [31:0] wd, input tag_t t);
        exp_req_t e;
        e.dest = sh_xlat[31:22];
        e.hop  = sh_xlat[19:12];
        e.off  = 24'({sh_xlat[11:0], 9'h000}) + 24'(a[21:0]);
        e.we   = we;
        e.size = sz_code(n);
        if (n == 1) begin
            e.lanes = 4'b1000 >> a[1:0];
            e.wdata = {24'h0, wd[7:0]} << (8 * (3 - a[1:0]));
        end else if (n == 2) begin
            e.lanes = a[1] ? 4'b0011 : 4'b1100;
            e.wdata = a[1] ? {16'h0, wd[15:0]} : {wd[15:0], 16'h0};
        end else begin
            e.lanes = 4'b1111;
            e.wdata = wd;
        end
        e.tag = t;
        return e;
    endfunction

    task automatic wr_cfg(input logic sel, input logic [31:0] v);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = v;
        @(negedge clk);
        cfg_wr = 1'b0;
        if (sel) sh_en = v[31]; else sh_xlat = v;
    endtask

    task automatic rd_cfg(input logic sel, input logic [31:0] exp, input tag_t t);
        @(negedge clk);
        cfg_sel = sel;
        #1;
        chk(cfg_rdata == exp, t, cfg_rdata, exp);
    endtask

    task automatic access_begin(input logic we, input logic [31:0] a, input int n,
                                input logic [31:0] wd, input logic [31:0] rd, input logic re,
                                input tag_t t, input bit with_cfg, input logic [31:0] cfg_v,
                                output bit hit);
        exp_done_t d;
        hit = sh_en && (a[31:22] == BASE[31:22]);
        d.tag = t;
        if (hit) begin
            rq.push_back(mk(we, a, n, wd, t));
            d.err   = re;
            d.rdata = we ? 32'h0 : exp_read(rd, n, a[1:0]);
        end else begin
            d.err   = 1'b1;
            d.rdata = 32'h0;
        end
        dq.push_back(d);
        @(negedge clk);
        bus_req = 1'b1; bus_we = we; bus_addr = a; bus_size = 3'(n); bus_wdata = wd;
        if (with_cfg) begin
            cfg_wr = 1'b1; cfg_sel = 1'b0; cfg_wdata = cfg_v;
        end
        @(negedge clk);
        bus_req = 1'b0;
        if (with_cfg) begin
            cfg_wr = 1'b0;
            sh_xlat = cfg_v;
        end
    endtask

    task automatic access_end(input bit hit, input logic [31:0] rd, input logic re);
        if (hit) begin
            @(negedge clk);
            rsp_valid = 1'b1; rsp_rdata = rd; rsp_err = re;
            @(negedge clk);
            rsp_valid = 1'b0; rsp_err = 1'b0;
        end
        @(negedge clk);
    endtask

    task automatic access(input logic we, input logic [31:0] a, input int n,
                          input logic [31:0] wd, input logic [31:0] rd, input logic re,
                          input tag_t t);
        bit h;
        access_begin(we, a, n, wd, rd, re, t, 1'b0, 32'h0, h);
        access_end(h, rd, re);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst) begin
            if (mreq_valid) begin
                if (rq.size() == 0) begin
                    chk(1'b0, "R9", {31'h0, mreq_valid}, 32'h0);
                end else begin
                    er = rq.pop_front();
                    chk(mreq_dest == er.dest, er.tag, {22'h0, mreq_dest}, {22'h0, er.dest});
                    chk(mreq_hop == er.hop, er.tag, {24'h0, mreq_hop}, {24'h0, er.hop});
                    chk(mreq_offset == er.off, er.tag, {8'h0, mreq_offset}, {8'h0, er.off});
                    chk(mreq_we == er.we, er.tag, {31'h0, mreq_we}, {31'h0, er.we});
                    chk(mreq_size == er.size, er.tag, {30'h0, mreq_size}, {30'h0, er.size});
                    chk(mreq_lanes == er.lanes, er.tag, {28'h0, mreq_lanes}, {28'h0, er.lanes});
                    chk(mreq_wdata == er.wdata, er.tag, mreq_wdata, er.wdata);
                end
            end
            if (bus_ack || bus_err) begin
                if (dq.size() == 0) begin
                    chk(1'b0, "R9", {30'h0, bus_ack, bus_err}, 32'h0);
                end else begin
                    ed = dq.pop_front();
                    chk(bus_err == ed.err, ed.tag, {31'h0, bus_err}, {31'h0, ed.err});
                    if (!ed.err) chk(bus_rdata == ed.rdata, ed.tag, bus_rdata, ed.rdata);
                end
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'h0, 32'h1);
        summary();
        $finish;
    end

    initial begin
        bit h;
        logic [9:0] held_dest;
        logic [23:0] held_off;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(bus_ready == 1'b1, "R1", {31'h0, bus_ready}, 32'h1);
        chk(mreq_valid == 1'b0, "R1", {31'h0, mreq_valid}, 32'h0);
        chk({bus_ack, bus_err} == 2'b00, "R1", {30'h0, bus_ack, bus_err}, 32'h0);
        rd_cfg(1'b0, 32'h0, "R1");
        rd_cfg(1'b1, 32'h0, "R1");

        // R2 register read-back
        wr_cfg(1'b0, 32'hA941_1123);
        rd_cfg(1'b0, 32'hA941_1123, "R2");
        wr_cfg(1'b1, 32'hFFFF_FFFF);
        rd_cfg(1'b1, 32'h8000_0000, "R2");
        wr_cfg(1'b1, 32'h0000_0000);
        rd_cfg(1'b1, 32'h0, "R2");

        // R4 window disabled
        access(1'b0, BASE + 32'h10, 4, 32'h0, 32'h0, 1'b0, "R4");
        chk(bus_ready == 1'b1, "R4", {31'h0, bus_ready}, 32'h1);

        wr_cfg(1'b1, 32'h8000_0000);
        // R3 / R5 word read
        access(1'b0, BASE + 32'h10, 4, 32'h0, 32'hDEAD_BEEF, 1'b0, "R3");
        access(1'b0, BASE + 32'h0012_3450, 4, 32'h0, 32'h0BAD_F00D, 1'b0, "R5");

        // R8 byte reads on every lane, R7 byte writes on every lane
        for (int k = 0; k < 4; k++)
            access(1'b0, BASE + 32'h100 + 32'(k), 1, 32'h0, 32'h1122_3344, 1'b0, "R8");
        for (int k = 0; k < 4; k++)
            access(1'b1, BASE + 32'h200 + 32'(k), 1, 32'hFFFF_FFA5, 32'h0, 1'b0, "R7");

        // R7 half writes, including odd address, R8 half read
        access(1'b1, BASE + 32'h300, 2, 32'h1234_BEEF, 32'h0, 1'b0, "R7");
        access(1'b1, BASE + 32'h302, 2, 32'h1234_BEEF, 32'h0, 1'b0, "R7");
        access(1'b1, BASE + 32'h303, 2, 32'h0000_C0DE, 32'h0, 1'b0, "R7");
        access(1'b0, BASE + 32'h302, 2, 32'h0, 32'hCAFE_F00D, 1'b0, "R8");
        access(1'b0, BASE + 32'h300, 2, 32'h0, 32'hCAFE_F00D, 1'b0, "R8");

        // R6 odd size codes become word accesses
        access(1'b0, BASE + 32'h400, 3, 32'h0, 32'h0102_0304, 1'b0, "R6");
        access(1'b1, BASE + 32'h404, 0, 32'h5566_7788, 32'h0, 1'b0, "R6");
        access(1'b0, BASE + 32'h408, 7, 32'h0, 32'h8877_6655, 1'b0, "R6");

        // R4 misses below and above the window
        access(1'b0, BASE - 32'h4, 4, 32'h0, 32'h0, 1'b0, "R4");
        access(1'b1, BASE + 32'h0040_0000, 4, 32'h1, 32'h0, 1'b0, "R4");

        // R10 response error, write acknowledge data
        access(1'b0, BASE + 32'h20, 4, 32'h0, 32'hFFFF_FFFF, 1'b1, "R10");
        access(1'b1, BASE + 32'h24, 4, 32'hABCD_0123, 32'hFFFF_FFFF, 1'b0, "R10");
        chk(bus_ready == 1'b1, "R10", {31'h0, bus_ready}, 32'h1);

        // R5 largest offsets
        wr_cfg(1'b0, 32'hFFC0_0FFF);
        access(1'b0, BASE + 32'h003F_FFFC, 4, 32'h0, 32'h7654_3210, 1'b0, "R5");

        // R11 register write in the acceptance cycle
        access_begin(1'b0, BASE + 32'h40, 4, 32'h0, 32'h1357_9BDF, 1'b0, "R11",
                     1'b1, 32'h4002_2001, h);
        access_end(h, 32'h1357_9BDF, 1'b0);
        access(1'b0, BASE + 32'h40, 4, 32'h0, 32'h2468_ACE0, 1'b0, "R11");

        // R12 rewrite while outstanding
        access_begin(1'b1, BASE + 32'h80, 4, 32'h0F0F_0F0F, 32'h0, 1'b0, "R12",
                     1'b0, 32'h0, h);
        held_dest = mreq_dest;
        held_off  = mreq_offset;
        wr_cfg(1'b0, 32'h1230_0ABC);
        chk(mreq_dest == held_dest, "R12", {22'h0, mreq_dest}, {22'h0, held_dest});
        chk(mreq_offset == held_off, "R12", {8'h0, mreq_offset}, {8'h0, held_off});
        access_end(h, 32'h0, 1'b0);

        // R9 request while busy is ignored
        access_begin(1'b0, BASE + 32'hC0, 1, 32'h0, 32'hAABB_CCDD, 1'b0, "R9",
                     1'b0, 32'h0, h);
        chk(bus_ready == 1'b0, "R9", {31'h0, bus_ready}, 32'h0);
        bus_req = 1'b1; bus_addr = 32'h1000_0000;
        @(negedge clk);
        bus_req = 1'b0;
        chk(bus_err == 1'b0, "R9", {31'h0, bus_err}, 32'h0);
        @(negedge clk);
        chk(bus_err == 1'b0 && mreq_valid == 1'b0, "R9", {30'h0, bus_err, mreq_valid}, 32'h0);
        access_end(h, 32'hAABB_CCDD, 1'b0);

        repeat (3) @(negedge clk);
        chk(rq.size() == 0 && dq.size() == 0, "R9", 32'(rq.size() + dq.size()), 32'h0);
        summary();
        $finish;
    end

endmodule